// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the register storage for a 32-bit processor that has several privilege modes. Software addresses sixteen architectural registers by a 4-bit index. The block turns each index into one of 31 physical words according to the 5-bit mode that the surrounding core presents. Registers 0 to 7 and 15 are common to every mode. Registers 8 to 12 have a separate copy for fast-interrupt mode. Registers 13 and 14 have one copy per privilege level, and User and System share a single copy. Each exception mode also owns a saved-status word.

The core reads two operands combinationally and writes one result per cycle. A second access path always addresses the User-level copies, whatever the current mode, so that the core can transfer user-view registers from inside an exception handler. Switching mode is only a change on the mode input: no data is copied, and the new mode sees its own words at once. A synchronous preset loads a fixed start-up image, so the core can skip the usual boot sequence.

Top module: `bankreg_file`

## Requirements
- R1: Indices 0–7 and 15 select one shared physical word each, and every mode code reads and writes that same word.
- R2: Indices 8–12 select one of two copies. Mode 5'b10001 (FIQ) uses the first copy and every other mode code uses the second.
- R3: Indices 13–14 select one of six copies. User (5'b10000) and System (5'b11111) share one copy. Supervisor (5'b10011), Abort (5'b10111), Undefined (5'b11011), IRQ (5'b10010) and FIQ each have a private copy.
- R4: Each of the five exception modes has its own saved-status word. `ss_valid_o` is 1 only in those modes. In any other mode a saved-status write is dropped and `ss_rd_data_o` reads 0.
- R5: The user-view ports always reach the User/System copy. From FIQ mode, indices 8–12 go to the non-FIQ copy. From any mode other than User or System, indices 13–14 go to the User/System copy.
- R6: Reads are combinational. A write becomes visible from the cycle after its clock edge, and a read of the same word in the write cycle returns the old value.
- R7: A write takes the copy selected by the mode present at its clock edge. A mode change after that edge does not move the write.
- R8: A cycle with `boot_i` high clears every word and then loads R0=0x08000000, R1=0x000000EA, User/System R13=0x03007F00, R15=0x08000000, IRQ R13=0x03007FA0 and Supervisor R13=0x03007FE0. All saved-status words become 0, and any write in the same cycle is dropped.
- R9: A mode code other than the seven listed in R2–R3 raises `mode_bad_o`, has no saved-status word, and maps registers exactly like User/System.
- R10: Asynchronous reset clears all 31 words and all 5 saved-status words to 0.
- R11: When the normal write port and the user-view write port address the same physical word in one cycle, the normal port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_i | input | 1 | Synchronous fast-start preset |
| mode_i | input | 5 | Current processor mode code |
| mode_bad_o | output | 1 | Mode code not recognised |
| ra_idx_i | input | 4 | Read port A register index |
| ra_data_o | output | 32 | Read port A data |
| rb_idx_i | input | 4 | Read port B register index |
| rb_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Normal write enable |
| wr_idx_i | input | 4 | Normal write index |
| wr_data_i | input | 32 | Normal write data |
| uv_rd_idx_i | input | 4 | User-view read index |
| uv_rd_data_o | output | 32 | User-view read data |
| uv_wr_en_i | input | 1 | User-view write enable |
| uv_wr_idx_i | input | 4 | User-view write index |
| uv_wr_data_i | input | 32 | User-view write data |
| ss_rd_data_o | output | 32 | Saved-status word of the current mode |
| ss_wr_en_i | input | 1 | Saved-status write enable |
| ss_wr_data_i | input | 32 | Saved-status write data |
| ss_valid_o | output | 1 | Current mode owns a saved-status word |

## Verification
The bench builds the block with its default 32-bit width and default preset image. At that size every mode code (all 32 values of the 5-bit field) can be paired with every one of the 16 indices on each port. A first sweep writes a distinct value into every index from each valid mode and then reads the whole view back from each mode. This exposes any aliasing between the 31 physical words. Later phases target the saved-status words, the user-view path from each mode, write/read timing, mode switching around a write, port conflicts, the unrecognised codes and the preset, and finish with a long random mix checked against a model that keeps the banks in a layout of its own.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

  localparam int IDX_W     = 4;
  localparam int MODE_W    = 5;
  localparam int COMMON_N  = 8;   // indices 0..7
  localparam int PC_IDX    = 15;
  localparam int HI_LO     = 8;   // first two-copy index
  localparam int HI_N      = 5;   // indices 8..12
  localparam int SP_IDX    = 13;
  localparam int LR_IDX    = 14;
  localparam int GROUPS    = 6;
  localparam int SAVED_N   = 5;
  localparam int HI_BASE   = COMMON_N + 1;
  localparam int GRP_BASE  = HI_BASE + 2 * HI_N;
  localparam int PHYS_N    = GRP_BASE + 2 * GROUPS;
  localparam int PHYS_W    = $clog2(PHYS_N);
  localparam int SAVED_W   = $clog2(SAVED_N);

  localparam logic [MODE_W-1:0] M_USR = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;
  localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

  typedef enum logic [2:0] {
    G_USRSYS = 3'd0,
    G_SVC    = 3'd1,
    G_ABT    = 3'd2,
    G_UND    = 3'd3,
    G_IRQ    = 3'd4,
    G_FIQ    = 3'd5
  } grp_e;

  typedef struct packed {
    logic               known;
    logic               fiq_set;
    grp_e               grp;
    logic               saved_ok;
    logic [SAVED_W-1:0] saved_idx;
  } view_t;

  // Mode code to bank selection; unknown codes fall back to User/System.
  function automatic view_t decode_mode(logic [MODE_W-1:0] m);
    view_t v;
    v.known     = 1'b1;
    v.fiq_set   = 1'b0;
    v.grp       = G_USRSYS;
    v.saved_ok  = 1'b0;
    v.saved_idx = '0;
    case (m)
      M_USR, M_SYS: ;
      M_SVC: begin v.grp = G_SVC; v.saved_ok = 1'b1; v.saved_idx = SAVED_W'(0); end
      M_ABT: begin v.grp = G_ABT; v.saved_ok = 1'b1; v.saved_idx = SAVED_W'(1); end
      M_UND: begin v.grp = G_UND; v.saved_ok = 1'b1; v.saved_idx = SAVED_W'(2); end
      M_IRQ: begin v.grp = G_IRQ; v.saved_ok = 1'b1; v.saved_idx = SAVED_W'(3); end
      M_FIQ: begin
        v.grp = G_FIQ; v.fiq_set = 1'b1;
        v.saved_ok = 1'b1; v.saved_idx = SAVED_W'(4);
      end
      default: v.known = 1'b0;
    endcase
    return v;
  endfunction

  // Architectural index plus bank selection to physical slot.
  // Layout: 0..7 common, 8 = PC, 9..18 two-copy pairs, 19..30 group pairs.
  function automatic logic [PHYS_W-1:0] phys_slot(logic [IDX_W-1:0] idx,
                                                  logic fiq_set, grp_e grp);
    int i;
    int s;
    i = int'(idx);
    if (i < COMMON_N)
      s = i;
    else if (i == PC_IDX)
      s = COMMON_N;
    else if (i < SP_IDX)
      s = HI_BASE + 2 * (i - HI_LO) + (fiq_set ? 1 : 0);
    else
      s = GRP_BASE + 2 * int'(grp) + (i - SP_IDX);
    return PHYS_W'(s);
  endfunction

endpackage

// File: rtl/bank_decode.sv
module bank_decode
  import bankreg_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output view_t             view_o,
  output logic              bad_o
);
  always_comb begin
    view_o = decode_mode(mode_i);
    bad_o  = ~view_o.known;
  end
endmodule

// File: rtl/bank_map.sv
module bank_map
  import bankreg_pkg::*;
#(
  parameter bit USER_VIEW = 1'b0
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  view_t             view_i,
  output logic [PHYS_W-1:0] slot_o
);
  generate
    if (USER_VIEW) begin : g_user
      logic unused_view;
      assign unused_view = ^view_i;
      assign slot_o = phys_slot(idx_i, 1'b0, G_USRSYS);
    end else begin : g_cur
      assign slot_o = phys_slot(idx_i, view_i.fiq_set, view_i.grp);
    end
  endgenerate
endmodule

// File: rtl/gpr_store.sv
module gpr_store
  import bankreg_pkg::*;
#(
  parameter int              DATA_W  = 32,
  parameter int              NRD     = 3,
  parameter logic [DATA_W-1:0] BOOT_R0 = DATA_W'(32'h0800_0000),
  parameter logic [DATA_W-1:0] BOOT_R1 = DATA_W'(32'h0000_00EA),
  parameter logic [DATA_W-1:0] BOOT_SP = DATA_W'(32'h0300_7F00),
  parameter logic [DATA_W-1:0] BOOT_PC = DATA_W'(32'h0800_0000),
  parameter logic [DATA_W-1:0] BOOT_SP_IRQ = DATA_W'(32'h0300_7FA0),
  parameter logic [DATA_W-1:0] BOOT_SP_SVC = DATA_W'(32'h0300_7FE0)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         boot_i,
  input  logic                         pa_we_i,
  input  logic [PHYS_W-1:0]            pa_slot_i,
  input  logic [DATA_W-1:0]            pa_data_i,
  input  logic                         pb_we_i,
  input  logic [PHYS_W-1:0]            pb_slot_i,
  input  logic [DATA_W-1:0]            pb_data_i,
  input  logic [NRD-1:0][PHYS_W-1:0]   rd_slot_i,
  output logic [NRD-1:0][DATA_W-1:0]   rd_data_o
);
  localparam logic [PHYS_W-1:0] S_R0  = phys_slot(IDX_W'(0), 1'b0, G_USRSYS);
  localparam logic [PHYS_W-1:0] S_R1  = phys_slot(IDX_W'(1), 1'b0, G_USRSYS);
  localparam logic [PHYS_W-1:0] S_PC  = phys_slot(IDX_W'(PC_IDX), 1'b0, G_USRSYS);
  localparam logic [PHYS_W-1:0] S_SP  = phys_slot(IDX_W'(SP_IDX), 1'b0, G_USRSYS);
  localparam logic [PHYS_W-1:0] S_SPI = phys_slot(IDX_W'(SP_IDX), 1'b0, G_IRQ);
  localparam logic [PHYS_W-1:0] S_SPS = phys_slot(IDX_W'(SP_IDX), 1'b0, G_SVC);

  logic [PHYS_N-1:0][DATA_W-1:0] regs_q;
  logic [PHYS_N-1:0][DATA_W-1:0] boot_image;
  logic                          wr_any;

  always_comb begin
    boot_image        = '0;
    boot_image[S_R0]  = BOOT_R0;
    boot_image[S_R1]  = BOOT_R1;
    boot_image[S_PC]  = BOOT_PC;
    boot_image[S_SP]  = BOOT_SP;
    boot_image[S_SPI] = BOOT_SP_IRQ;
    boot_image[S_SPS] = BOOT_SP_SVC;
  end

  assign wr_any = pa_we_i | pb_we_i;

  // Port A is applied last so it wins a same-slot collision.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (boot_i) begin
      regs_q <= boot_image;
    end else begin
      if (pb_we_i) regs_q[pb_slot_i] <= pb_data_i;
      if (pa_we_i) regs_q[pa_slot_i] <= pa_data_i;
    end
  end

  generate
    for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rd_data_o[g] = regs_q[rd_slot_i[g]];
    end
  endgenerate

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_any && !boot_i) |=> $stable(regs_q));

  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_we_i && !boot_i) |=> (regs_q[$past(pa_slot_i)] == $past(pa_data_i)));

  p_boot_image_r8: assert property (@(posedge clk) disable iff (!rst_n)
    boot_i |=> (regs_q[S_R0] == BOOT_R0 && regs_q[S_PC] == BOOT_PC &&
                regs_q[S_SPI] == BOOT_SP_IRQ && regs_q[S_SPS] == BOOT_SP_SVC));

endmodule

// File: rtl/saved_store.sv
module saved_store
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boot_i,
  input  logic               ok_i,
  input  logic [SAVED_W-1:0] idx_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [DATA_W-1:0]  data_o
);
  logic [SAVED_N-1:0][DATA_W-1:0] bank_q;
  logic                           we_eff;

  assign we_eff = we_i & ok_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bank_q <= '0;
    else if (boot_i)   bank_q <= '0;
    else if (we_eff)   bank_q[idx_i] <= data_i;
  end

  assign data_o = ok_i ? bank_q[idx_i] : '0;

  p_saved_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(we_i && ok_i) && !boot_i) |=> $stable(bank_q));

  p_saved_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_i |-> (data_o == '0));

endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
  import bankreg_pkg::*;
#(
  parameter int              DATA_W      = 32,
  parameter logic [DATA_W-1:0] BOOT_R0     = DATA_W'(32'h0800_0000),
  parameter logic [DATA_W-1:0] BOOT_R1     = DATA_W'(32'h0000_00EA),
  parameter logic [DATA_W-1:0] BOOT_SP     = DATA_W'(32'h0300_7F00),
  parameter logic [DATA_W-1:0] BOOT_PC     = DATA_W'(32'h0800_0000),
  parameter logic [DATA_W-1:0] BOOT_SP_IRQ = DATA_W'(32'h0300_7FA0),
  parameter logic [DATA_W-1:0] BOOT_SP_SVC = DATA_W'(32'h0300_7FE0)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_i,
  input  logic [4:0]        mode_i,
  output logic              mode_bad_o,
  input  logic [3:0]        ra_idx_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [3:0]        rb_idx_i,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [3:0]        uv_rd_idx_i,
  output logic [DATA_W-1:0] uv_rd_data_o,
  input  logic              uv_wr_en_i,
  input  logic [3:0]        uv_wr_idx_i,
  input  logic [DATA_W-1:0] uv_wr_data_i,
  output logic [DATA_W-1:0] ss_rd_data_o,
  input  logic              ss_wr_en_i,
  input  logic [DATA_W-1:0] ss_wr_data_i,
  output logic              ss_valid_o
);
  // Lanes 0..2 follow the current mode, lanes 3..4 use the user view.
  localparam int LANES     = 5;
  localparam int FIRST_USR = 3;
  localparam int NRD       = 3;

  view_t                        view;
  logic [LANES-1:0][IDX_W-1:0]  lane_idx;
  logic [LANES-1:0][PHYS_W-1:0] lane_slot;
  logic [NRD-1:0][PHYS_W-1:0]   rd_slot;
  logic [NRD-1:0][DATA_W-1:0]   rd_data;

  bank_decode i_decode (
    .mode_i (mode_i),
    .view_o (view),
    .bad_o  (mode_bad_o)
  );

  assign lane_idx[0] = ra_idx_i;
  assign lane_idx[1] = rb_idx_i;
  assign lane_idx[2] = wr_idx_i;
  assign lane_idx[3] = uv_rd_idx_i;
  assign lane_idx[4] = uv_wr_idx_i;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      bank_map #(.USER_VIEW(l >= FIRST_USR)) i_map (
        .idx_i  (lane_idx[l]),
        .view_i (view),
        .slot_o (lane_slot[l])
      );
    end
  endgenerate

  assign rd_slot[0] = lane_slot[0];
  assign rd_slot[1] = lane_slot[1];
  assign rd_slot[2] = lane_slot[3];

  gpr_store #(
    .DATA_W      (DATA_W),
    .NRD         (NRD),
    .BOOT_R0     (BOOT_R0),
    .BOOT_R1     (BOOT_R1),
    .BOOT_SP     (BOOT_SP),
    .BOOT_PC     (BOOT_PC),
    .BOOT_SP_IRQ (BOOT_SP_IRQ),
    .BOOT_SP_SVC (BOOT_SP_SVC)
  ) i_gpr (
    .clk       (clk),
    .rst_n     (rst_n),
    .boot_i    (boot_i),
    .pa_we_i   (wr_en_i),
    .pa_slot_i (lane_slot[2]),
    .pa_data_i (wr_data_i),
    .pb_we_i   (uv_wr_en_i),
    .pb_slot_i (lane_slot[4]),
    .pb_data_i (uv_wr_data_i),
    .rd_slot_i (rd_slot),
    .rd_data_o (rd_data)
  );

  assign ra_data_o    = rd_data[0];
  assign rb_data_o    = rd_data[1];
  assign uv_rd_data_o = rd_data[2];
  assign ss_valid_o   = view.saved_ok;

  saved_store #(.DATA_W(DATA_W)) i_saved (
    .clk    (clk),
    .rst_n  (rst_n),
    .boot_i (boot_i),
    .ok_i   (view.saved_ok),
    .idx_i  (view.saved_idx),
    .we_i   (ss_wr_en_i),
    .data_i (ss_wr_data_i),
    .data_o (ss_rd_data_o)
  );

  p_common_same_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((ra_idx_i == uv_rd_idx_i) && ((ra_idx_i < 4'd8) || (ra_idx_i == 4'd15)))
      |-> (ra_data_o == uv_rd_data_o));

  p_user_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == M_USR || mode_i == M_SYS) && (ra_idx_i == uv_rd_idx_i))
      |-> (ra_data_o == uv_rd_data_o));

  p_bad_fallback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bad_o && (rb_idx_i == uv_rd_idx_i)) |-> (rb_data_o == uv_rd_data_o));

  p_bad_no_saved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_bad_o |-> !ss_valid_o);

endmodule

// File: tb/test_bankreg_file.sv
module test_bankreg_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_i = 1'b0;
  logic [4:0]  mode_i = 5'b11111;
  logic        mode_bad_o;
  logic [3:0]  ra_idx_i = '0, rb_idx_i = '0, wr_idx_i = '0, uv_rd_idx_i = '0, uv_wr_idx_i = '0;
  logic [31:0] ra_data_o, rb_data_o, uv_rd_data_o, ss_rd_data_o;
  logic        wr_en_i = 1'b0, uv_wr_en_i = 1'b0, ss_wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0, uv_wr_data_i = '0, ss_wr_data_i = '0;
  logic        ss_valid_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  bankreg_file i_bankreg_file (
    .clk(clk), .rst_n(rst_n), .boot_i(boot_i), .mode_i(mode_i), .mode_bad_o(mode_bad_o),
    .ra_idx_i(ra_idx_i), .ra_data_o(ra_data_o), .rb_idx_i(rb_idx_i), .rb_data_o(rb_data_o),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .uv_rd_idx_i(uv_rd_idx_i), .uv_rd_data_o(uv_rd_data_o),
    .uv_wr_en_i(uv_wr_en_i), .uv_wr_idx_i(uv_wr_idx_i), .uv_wr_data_i(uv_wr_data_i),
    .ss_rd_data_o(ss_rd_data_o), .ss_wr_en_i(ss_wr_en_i), .ss_wr_data_i(ss_wr_data_i),
    .ss_valid_o(ss_valid_o)
  );

  // Reference model, laid out by bank rather than by slot.
  logic [31:0] m_common [16];
  logic [31:0] m_hi [2][5];     // [0]=non-FIQ copy, [1]=FIQ copy
  logic [31:0] m_grp [6][2];    // [group][0=R13,1=R14]
  logic [31:0] m_saved [5];

  function automatic logic [4:0] mode_at(int k);
    case (k)
      0: return 5'b10000; 1: return 5'b10001; 2: return 5'b10010; 3: return 5'b10011;
      4: return 5'b10111; 5: return 5'b11011; default: return 5'b11111;
    endcase
  endfunction

  function automatic int grp_of(logic [4:0] m);
    case (m)
      5'b10011: return 1; 5'b10111: return 2; 5'b11011: return 3;
      5'b10010: return 4; 5'b10001: return 5; default: return 0;
    endcase
  endfunction

  function automatic int saved_of(logic [4:0] m);
    case (m)
      5'b10011: return 0; 5'b10111: return 1; 5'b11011: return 2;
      5'b10010: return 3; 5'b10001: return 4; default: return -1;
    endcase
  endfunction

  function automatic bit known(logic [4:0] m);
    for (int k = 0; k < 7; k++) if (mode_at(k) == m) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string tag_of(int idx);
    if (idx >= 8 && idx <= 12) return "R2";
    if (idx == 13 || idx == 14) return "R3";
    return "R1";
  endfunction

  function automatic logic [31:0] m_read(logic [4:0] m, int idx, bit usr);
    if (idx >= 8 && idx <= 12) return m_hi[(!usr && m == 5'b10001) ? 1 : 0][idx-8];
    if (idx == 13 || idx == 14) return m_grp[usr ? 0 : grp_of(m)][idx-13];
    return m_common[idx];
  endfunction

  task automatic m_write(logic [4:0] m, int idx, bit usr, logic [31:0] v);
    if (idx >= 8 && idx <= 12) m_hi[(!usr && m == 5'b10001) ? 1 : 0][idx-8] = v;
    else if (idx == 13 || idx == 14) m_grp[usr ? 0 : grp_of(m)][idx-13] = v;
    else m_common[idx] = v;
  endtask

  task automatic m_clear();
    for (int i = 0; i < 16; i++) m_common[i] = '0;
    for (int c = 0; c < 2; c++) for (int i = 0; i < 5; i++) m_hi[c][i] = '0;
    for (int g = 0; g < 6; g++) begin m_grp[g][0] = '0; m_grp[g][1] = '0; end
    for (int s = 0; s < 5; s++) m_saved[s] = '0;
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wr_norm(logic [4:0] m, int idx, logic [31:0] v);
    @(negedge clk);
    mode_i = m; wr_en_i = 1'b1; wr_idx_i = 4'(idx); wr_data_i = v;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
    m_write(m, idx, 1'b0, v);
  endtask

  task automatic wr_user(logic [4:0] m, int idx, logic [31:0] v);
    @(negedge clk);
    mode_i = m; uv_wr_en_i = 1'b1; uv_wr_idx_i = 4'(idx); uv_wr_data_i = v;
    @(posedge clk); #1;
    uv_wr_en_i = 1'b0;
    m_write(m, idx, 1'b1, v);
  endtask

  task automatic wr_saved(logic [4:0] m, logic [31:0] v);
    @(negedge clk);
    mode_i = m; ss_wr_en_i = 1'b1; ss_wr_data_i = v;
    @(posedge clk); #1;
    ss_wr_en_i = 1'b0;
    if (saved_of(m) >= 0) m_saved[saved_of(m)] = v;
  endtask

  // Read the whole view of one mode through all three read ports.
  task automatic check_view(logic [4:0] m, string tag_over);
    for (int idx = 0; idx < 16; idx++) begin
      string t;
      t = (tag_over == "") ? tag_of(idx) : tag_over;
      @(negedge clk);
      mode_i = m; ra_idx_i = 4'(idx); rb_idx_i = 4'(15 - idx); uv_rd_idx_i = 4'(idx);
      #1;
      chk(t, $sformatf("mode=%b portA idx=%0d", m, idx), ra_data_o, m_read(m, idx, 1'b0));
      chk(tag_of(15 - idx), $sformatf("mode=%b portB idx=%0d", m, 15 - idx), rb_data_o,
          m_read(m, 15 - idx, 1'b0));
      chk((tag_over == "") ? "R5" : tag_over, $sformatf("mode=%b user idx=%0d", m, idx),
          uv_rd_data_o, m_read(m, idx, 1'b1));
    end
  endtask

  task automatic check_saved(logic [4:0] m, string tag);
    @(negedge clk);
    mode_i = m; #1;
    chk(tag, $sformatf("saved valid mode=%b", m), 32'(ss_valid_o), 32'(saved_of(m) >= 0));
    chk(tag, $sformatf("saved data mode=%b", m), ss_rd_data_o,
        (saved_of(m) >= 0) ? m_saved[saved_of(m)] : 32'h0);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] old_v;
    m_clear();
    repeat (3) @(negedge clk);
    // R10: reset state, before any write
    for (int k = 0; k < 7; k++) check_view(mode_at(k), "R10");
    for (int k = 0; k < 7; k++) check_saved(mode_at(k), "R10");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3: distinct value into every index from every mode, then read all views
    for (int k = 0; k < 7; k++)
      for (int idx = 0; idx < 16; idx++)
        wr_norm(mode_at(k), idx, {8'hA0 + 8'(k), 8'(idx), 16'($urandom())});
    for (int k = 0; k < 7; k++) check_view(mode_at(k), "");

    // R4: saved-status words per mode, writes dropped where none exists
    for (int k = 0; k < 7; k++) wr_saved(mode_at(k), 32'h5A00_0000 + 32'(k));
    wr_saved(5'b00000, 32'hDEAD_BEEF);
    for (int k = 0; k < 7; k++) check_saved(mode_at(k), "R4");

    // R5: user-view writes from every mode
    for (int k = 0; k < 7; k++)
      for (int idx = 0; idx < 16; idx++)
        wr_user(mode_at(k), idx, {8'hC0 + 8'(k), 8'(idx), 16'($urandom())});
    for (int k = 0; k < 7; k++) check_view(mode_at(k), "");

    // R6: same-cycle read returns old value, new value next cycle
    @(negedge clk);
    mode_i = 5'b11111; ra_idx_i = 4'd3; old_v = m_read(5'b11111, 3, 1'b0);
    wr_en_i = 1'b1; wr_idx_i = 4'd3; wr_data_i = 32'h1234_5678;
    #1 chk("R6", "read during write", ra_data_o, old_v);
    @(posedge clk); #1;
    wr_en_i = 1'b0; m_write(5'b11111, 3, 1'b0, 32'h1234_5678);
    chk("R6", "read after write", ra_data_o, 32'h1234_5678);

    // R7: write in FIQ then leave FIQ right after the edge
    @(negedge clk);
    mode_i = 5'b10001; wr_en_i = 1'b1; wr_idx_i = 4'd9; wr_data_i = 32'hF1F1_0009;
    @(posedge clk); #1;
    wr_en_i = 1'b0; mode_i = 5'b10011; ra_idx_i = 4'd9;
    m_write(5'b10001, 9, 1'b0, 32'hF1F1_0009);
    #1 chk("R7", "svc view of r9 after fiq write", ra_data_o, m_read(5'b10011, 9, 1'b0));
    @(negedge clk);
    mode_i = 5'b10001; wr_en_i = 1'b1; wr_idx_i = 4'd13; wr_data_i = 32'hF1F1_000D;
    @(posedge clk); #1;
    wr_en_i = 1'b0; mode_i = 5'b10010;
    m_write(5'b10001, 13, 1'b0, 32'hF1F1_000D);
    check_view(5'b10001, "R7");
    check_view(5'b10010, "R7");

    // R11: both write ports on the same slot
    @(negedge clk);
    mode_i = 5'b10000;
    wr_en_i = 1'b1; wr_idx_i = 4'd10; wr_data_i = 32'hAAAA_0001;
    uv_wr_en_i = 1'b1; uv_wr_idx_i = 4'd10; uv_wr_data_i = 32'hBBBB_0002;
    @(posedge clk); #1;
    wr_en_i = 1'b0; uv_wr_en_i = 1'b0;
    m_write(5'b10000, 10, 1'b0, 32'hAAAA_0001);
    ra_idx_i = 4'd10;
    #1 chk("R11", "collision winner", ra_data_o, 32'hAAAA_0001);

    // R9: every unrecognised mode code
    for (int c = 0; c < 32; c++) begin
      if (!known(5'(c))) begin
        @(negedge clk);
        mode_i = 5'(c); ra_idx_i = 4'd13; rb_idx_i = 4'd8; #1;
        chk("R9", $sformatf("bad flag code=%b", 5'(c)), 32'(mode_bad_o), 32'd1);
        chk("R9", $sformatf("no saved code=%b", 5'(c)), 32'(ss_valid_o), 32'd0);
        chk("R9", $sformatf("r13 fallback code=%b", 5'(c)), ra_data_o, m_grp[0][0]);
        chk("R9", $sformatf("r8 fallback code=%b", 5'(c)), rb_data_o, m_hi[0][0]);
      end else begin
        @(negedge clk);
        mode_i = 5'(c); #1;
        chk("R9", $sformatf("no bad flag code=%b", 5'(c)), 32'(mode_bad_o), 32'd0);
      end
    end
    wr_norm(5'b01010, 14, 32'h0BAD_000E);
    check_view(5'b11111, "R9");

    // Random mix against the model
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] m;
      int idx;
      m = ($urandom() % 8 == 0) ? 5'($urandom()) : mode_at(int'($urandom() % 7));
      idx = int'($urandom() % 16);
      case ($urandom() % 4)
        0: wr_norm(m, idx, $urandom());
        1: wr_user(m, idx, $urandom());
        2: wr_saved(m, $urandom());
        default: begin
          @(negedge clk);
          mode_i = m; ra_idx_i = 4'(idx); uv_rd_idx_i = 4'(idx); #1;
          chk(tag_of(idx), "random port A", ra_data_o, m_read(m, idx, 1'b0));
          chk("R5", "random user view", uv_rd_data_o, m_read(m, idx, 1'b1));
          chk("R4", "random saved", ss_rd_data_o,
              (saved_of(m) >= 0) ? m_saved[saved_of(m)] : 32'h0);
        end
      endcase
    end

    // R8: preset with a competing write
    @(negedge clk);
    mode_i = 5'b11111; boot_i = 1'b1;
    wr_en_i = 1'b1; wr_idx_i = 4'd0; wr_data_i = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    boot_i = 1'b0; wr_en_i = 1'b0;
    m_clear();
    m_common[0] = 32'h0800_0000; m_common[1] = 32'h0000_00EA; m_common[15] = 32'h0800_0000;
    m_grp[0][0] = 32'h0300_7F00; m_grp[4][0] = 32'h0300_7FA0; m_grp[1][0] = 32'h0300_7FE0;
    for (int k = 0; k < 7; k++) check_view(mode_at(k), "R8");
    for (int k = 0; k < 7; k++) check_saved(mode_at(k), "R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule